// File: doc/BRIEF.md
# Split-Channel Memory-to-Memory DMA

This block copies data from one memory region to another with two cooperating channels. A reader channel fetches elements from memory and loads them into a shared 16-entry, 32-bit FIFO. A writer channel drains the FIFO and stores the elements to memory. Each channel walks its own linked chain of descriptors, and each has its own start pointer, so two different masters can program the two sides. The two chains are coupled only through the FIFO, so every pair of descriptors must agree.

Each channel has a word-wide request/grant memory port. It uses that port for descriptor fetches, data beats and status writeback. Elements of 8, 16 or 32 bits are moved. A narrow element takes its own FIFO entry and uses only the byte lanes that match its address. When the two descriptors of a pair disagree, both channels stop before moving any data and report the error. When a descriptor completes, the channel writes a status word and can raise an interrupt. It then follows the chain or stops.

Top module: `mdma_pair`

## Requirements
- R1: A start pulse is accepted only while that channel is idle and its head pointer is nonzero. Otherwise the pulse is ignored and no memory request results from it.
- R2: A descriptor is five words at its pointer P. P+0 holds the next pointer, P+4 the start address and P+8 the element count. P+12 holds the config word: bit0 enable, bits 2:1 size (00 = 8-bit, 01 = 16-bit, 10 = 32-bit), bit3 interrupt enable and bit4 last. P+16 is the status word.
- R3: The FIFO holds 16 elements. The reader stops requesting data while the FIFO is full, and the writer stops while it is empty. No element is lost or duplicated.
- R4: A narrow element is taken from, and placed at, the byte lanes selected by address bits 1:0. The writer drives byte enables 0001, 0011 or 1111 shifted left by those bits. The address then steps by 1, 2 or 4.
- R5: If the paired descriptors differ in count, size or enable bit, both channels write status 0x2 and go idle with no data beats. `pair_err` stays high until the next accepted start.
- R6: When a channel finishes a descriptor, it writes status 0x1. It pulses its interrupt for exactly one cycle only if bit3 is set. An error writeback raises no interrupt.
- R7: After completion, a channel loads the descriptor at the next pointer. It goes idle instead when the last flag is set or the next pointer is zero.
- R8: A memory request holds with a stable address until it is granted. The beat completes in the grant cycle, and read data is taken in that cycle. After reset no request is raised.
- R9: A pair whose descriptors both have the enable bit clear ends both chains. No data beats and no status writes are made.
- R10: A matched pair with count zero moves no data but still completes with status writeback and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_start | input | 1 | Start pulse for the reader chain |
| src_head | input | 32 | First descriptor pointer of the reader chain |
| dst_start | input | 1 | Start pulse for the writer chain |
| dst_head | input | 32 | First descriptor pointer of the writer chain |
| s_req | output | 1 | Reader port request |
| s_we | output | 1 | Reader port write (status only) |
| s_addr | output | 32 | Reader port word address |
| s_wdata | output | 32 | Reader port write data |
| s_be | output | 4 | Reader port byte enables |
| s_gnt | input | 1 | Reader port grant |
| s_rdata | input | 32 | Reader port read data, valid with grant |
| d_req | output | 1 | Writer port request |
| d_we | output | 1 | Writer port write |
| d_addr | output | 32 | Writer port word address |
| d_wdata | output | 32 | Writer port write data |
| d_be | output | 4 | Writer port byte enables |
| d_gnt | input | 1 | Writer port grant |
| d_rdata | input | 32 | Writer port read data, valid with grant |
| src_irq | output | 1 | Reader completion pulse |
| dst_irq | output | 1 | Writer completion pulse |
| pair_err | output | 1 | Descriptor pair mismatch flag |

## Verification
The assertions assume that memory returns read data in the same cycle as the grant and that a grant only comes with a request. They also assume that every data address is naturally aligned for its element size, so a narrow element never straddles a word boundary. The bench memory model grants only requested beats and reads combinationally. It adds stalls from a pseudo-random sequence or from explicit holds. Every table entry and directed case uses byte, halfword or word addresses aligned to the element size.

// File: rtl/mdma_pair.sv
module mdma_pair #(
  parameter int DEPTH = 16,
  parameter int CW    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_start,
  input  logic [31:0] src_head,
  input  logic        dst_start,
  input  logic [31:0] dst_head,
  output logic        s_req,
  output logic        s_we,
  output logic [31:0] s_addr,
  output logic [31:0] s_wdata,
  output logic [3:0]  s_be,
  input  logic        s_gnt,
  input  logic [31:0] s_rdata,
  output logic        d_req,
  output logic        d_we,
  output logic [31:0] d_addr,
  output logic [31:0] d_wdata,
  output logic [3:0]  d_be,
  input  logic        d_gnt,
  input  logic [31:0] d_rdata,
  output logic        src_irq,
  output logic        dst_irq,
  output logic        pair_err
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] NFULL = (AW+1)'(DEPTH);

  typedef enum logic [2:0] {IDLE, FETCH, READY, XFER, WBACK, ERRWB} st_t;

  st_t           st    [2];
  logic [CW-1:0] cnt   [2];
  logic [4:0]    cfg   [2];
  logic [1:0]    adrl  [2];
  logic [31:0]   head  [2];
  logic [31:0]   addr  [2];
  logic [31:0]   wdata [2];
  logic [31:0]   rdata [2];
  logic [3:0]    be    [2];
  logic [1:0]    start, gnt, req, we, go, irq, acc;

  logic [31:0]   fmem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fcnt;
  logic          full, empty, push, pop, pair, bad;
  logic [31:0]   lane0, fifo_out;

  assign start    = {dst_start, src_start};
  assign gnt      = {d_gnt, s_gnt};
  assign head[0]  = src_head;
  assign head[1]  = dst_head;
  assign rdata[0] = s_rdata;
  assign rdata[1] = d_rdata;

  assign s_req = req[0];  assign s_we = we[0];  assign s_addr = addr[0];
  assign s_wdata = wdata[0];  assign s_be = be[0];
  assign d_req = req[1];  assign d_we = we[1];  assign d_addr = addr[1];
  assign d_wdata = wdata[1];  assign d_be = be[1];
  assign src_irq = irq[0];
  assign dst_irq = irq[1];

  assign full     = fcnt == NFULL;
  assign empty    = fcnt == '0;
  assign push     = go[0] & gnt[0];
  assign pop      = go[1] & gnt[1];
  assign fifo_out = fmem[rp];
  assign lane0    = (s_rdata >> {adrl[0], 3'b000}) &
                    ((cfg[0][2:1] == 2'd0) ? 32'h0000_00FF :
                     (cfg[0][2:1] == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF);

  assign pair = (st[0] == READY) && (st[1] == READY);
  assign bad  = (cnt[0] != cnt[1]) || (cfg[0][2:0] != cfg[1][2:0]);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    st_t           s;
    logic [31:0]   p, n, a;
    logic [4:0]    g;
    logic [CW-1:0] k;
    logic [1:0]    w;
    logic          q, fire;
    logic [2:0]    step;
    logic [3:0]    lm;

    assign step = (g[2:1] == 2'd0) ? 3'd1 : (g[2:1] == 2'd1) ? 3'd2 : 3'd4;
    assign lm   = (g[2:1] == 2'd0) ? 4'b0001 : (g[2:1] == 2'd1) ? 4'b0011 : 4'b1111;
    assign acc[c]   = (s == IDLE) && start[c] && (head[c] != '0);
    assign go[c]    = (s == XFER) && (k != '0) && ((c == 0) ? !full : !empty);
    assign req[c]   = (s == FETCH) || (s == WBACK) || (s == ERRWB) || go[c];
    assign we[c]    = (s == WBACK) || (s == ERRWB) || ((c == 1) && go[c]);
    assign addr[c]  = (s == FETCH) ? p + {28'd0, w, 2'b00} :
                      (s == XFER)  ? {a[31:2], 2'b00} : p + 32'd16;
    assign wdata[c] = (s == ERRWB) ? 32'h2 : (s == WBACK) ? 32'h1 :
                      fifo_out << {a[1:0], 3'b000};
    assign be[c]    = (s == XFER) ? lm << a[1:0] : 4'hF;
    assign fire     = req[c] & gnt[c];
    assign st[c]    = s;
    assign cnt[c]   = k;
    assign cfg[c]   = g;
    assign adrl[c]  = a[1:0];
    assign irq[c]   = q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s <= IDLE;  p <= '0;  n <= '0;  a <= '0;
        g <= '0;    k <= '0;  w <= '0;  q <= 1'b0;
      end else begin
        q <= 1'b0;
        case (s)
          IDLE: if (acc[c]) begin
            p <= head[c];
            w <= '0;
            s <= FETCH;
          end
          FETCH: if (fire) begin
            case (w)
              2'd0:    n <= rdata[c];
              2'd1:    a <= rdata[c];
              2'd2:    k <= rdata[c][CW-1:0];
              default: g <= rdata[c][4:0];
            endcase
            w <= w + 2'd1;
            if (w == 2'd3) s <= READY;
          end
          READY: if (pair) s <= bad ? ERRWB : (g[0] ? XFER : IDLE);
          XFER: begin
            if (k == '0) s <= WBACK;
            else if (fire) begin
              a <= a + {29'd0, step};
              k <= k - 1'b1;
            end
          end
          WBACK: if (fire) begin
            q <= g[3];
            p <= n;
            w <= '0;
            s <= (g[4] || n == '0) ? IDLE : FETCH;
          end
          ERRWB: if (fire) s <= IDLE;
          default: s <= IDLE;
        endcase
      end
    end

    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req[c] && !gnt[c] |=> req[c] && $stable(addr[c]));
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q |=> !q);

    if (c == 1) begin : g_lane
      p_lane_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go[c] |-> $countones(be[c]) == int'(step));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pair_err <= 1'b0;
    else if (pair && bad) pair_err <= 1'b1;
    else if (|acc)        pair_err <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;  rp <= '0;  fcnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      fcnt <= fcnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) if (push) fmem[wp] <= lane0;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(st[0] == XFER && s_req));
  p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !(st[1] == XFER && d_req));
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |-> st[0] != XFER && st[1] != XFER);
  p_pair_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st[0] == XFER && st[1] == XFER |-> cfg[0][2:0] == cfg[1][2:0]);
endmodule

// File: tb/tb_mdma_pair.sv
`timescale 1ns/1ps
module tb_mdma_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic src_start = 0, dst_start = 0;
  logic [31:0] src_head = 0, dst_head = 0;
  logic s_req, s_we, s_gnt, d_req, d_we, d_gnt;
  logic [31:0] s_addr, s_wdata, s_rdata, d_addr, d_wdata, d_rdata;
  logic [3:0] s_be, d_be;
  logic src_irq, dst_irq, pair_err;

  always #4 clk = ~clk;

  mdma_pair dut (.*);

  logic [31:0] mem [1024];
  logic        bw_en = 0;
  logic [31:0] bw_addr = 0, bw_data = 0;
  logic        stall = 0, s_hold = 0, d_hold = 0, s_ok = 1, d_ok = 1;
  logic [7:0]  lf = 8'hA5;
  int nsread = 0, ndwrite = 0, nreq = 0, nalt = 0, nsirq = 0, ndirq = 0;
  int checks = 0, errors = 0;

  assign s_rdata = mem[s_addr[11:2]];
  assign d_rdata = mem[d_addr[11:2]];
  assign s_gnt   = s_req & s_ok & !s_hold;
  assign d_gnt   = d_req & d_ok & !d_hold;

  always @(posedge clk) begin
    lf   <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    s_ok <= !stall | lf[0];
    d_ok <= !stall | lf[2];
    if (bw_en) mem[bw_addr[11:2]] <= bw_data;
    for (int b = 0; b < 4; b++) begin
      if (s_gnt && s_we && s_be[b]) mem[s_addr[11:2]][8*b +: 8] <= s_wdata[8*b +: 8];
      if (d_gnt && d_we && d_be[b]) mem[d_addr[11:2]][8*b +: 8] <= d_wdata[8*b +: 8];
    end
    if (s_gnt && !s_we && s_addr >= 32'h400 && s_addr < 32'h800) nsread <= nsread + 1;
    if (d_gnt && d_we && d_addr >= 32'h800 && d_addr < 32'hC00) ndwrite <= ndwrite + 1;
    if (s_req || d_req) nreq <= nreq + 1;
    if (s_gnt && s_addr >= 32'h180 && s_addr < 32'h194) nalt <= nalt + 1;
    if (src_irq) nsirq <= nsirq + 1;
    if (dst_irq) ndirq <= ndirq + 1;
  end

  typedef struct packed {
    logic [1:0]  sz;
    logic [7:0]  n;
    logic [11:0] so;
    logic [11:0] dp;
    logic        st;
  } vec_t;
  localparam vec_t VT [6] = '{
    '{2'd2, 8'd20, 12'h400, 12'h800, 1'b0},
    '{2'd0, 8'd37, 12'h403, 12'h801, 1'b1},
    '{2'd1, 8'd22, 12'h40A, 12'h806, 1'b1},
    '{2'd2, 8'd40, 12'h480, 12'h840, 1'b1},
    '{2'd0, 8'd5,  12'h4F1, 12'h80E, 1'b0},
    '{2'd1, 8'd1,  12'h402, 12'h802, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] srcb(input int a);
    return 8'((a * 29 + 11) ^ (a >> 5));
  endfunction

  function automatic logic [7:0] getb(input int a);
    return 8'(mem[a[11:2]] >> (8 * a[1:0]));
  endfunction

  function automatic logic [31:0] mkcfg(input bit en, input logic [1:0] sz, input bit ie, input bit last);
    return {27'd0, last, ie, sz, en};
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] p, input logic [31:0] nx, input logic [31:0] a,
                          input logic [31:0] n, input logic [31:0] cf);
    poke(p, nx); poke(p + 4, a); poke(p + 8, n); poke(p + 12, cf); poke(p + 16, 32'hDEAD);
  endtask

  task automatic clear_dst();
    for (int w = 32'h800; w < 32'h900; w += 4) poke(w, 32'h0);
  endtask

  task automatic kick(input logic [31:0] sh, input logic [31:0] dh);
    src_head = sh; dst_head = dh; src_start = 1'b1; dst_start = 1'b1;
    @(negedge clk);
    src_start = 1'b0; dst_start = 1'b0;
  endtask

  task automatic wait_irq(input int target, input string req);
    int t = 0;
    while (ndirq < target && t < 5000) begin @(negedge clk); t++; end
    chk(ndirq >= target, req, ndirq, target);
    repeat (40) @(negedge clk);
  endtask

  task automatic check_copy(input string req, input int so, input int dp, input int nb);
    int bad_at = -1;
    for (int i = 0; i < nb; i++)
      if (bad_at < 0 && getb(dp + i) !== srcb(so + i)) bad_at = i;
    if (bad_at < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, getb(dp + bad_at), srcb(so + bad_at));
    chk(getb(dp + nb) === 8'h00, req, getb(dp + nb), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, d1, d2, d3, i0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!s_req && !d_req, "R8 reset", {s_req, d_req}, 0);
    chk(!src_irq && !dst_irq && !pair_err, "R6 reset", {src_irq, dst_irq, pair_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 32'h400; w < 32'h800; w += 4)
      poke(w, {srcb(w + 3), srcb(w + 2), srcb(w + 1), srcb(w)});

    // R1 zero head ignored
    d0 = nreq;
    kick(0, 0);
    repeat (30) @(negedge clk);
    chk(nreq == d0, "R1 zero head", nreq - d0, 0);

    // table of transfers: R2 R3 R4 R6
    foreach (VT[v]) begin
      clear_dst();
      set_desc(32'h100, 0, {20'd0, VT[v].so}, {24'd0, VT[v].n}, mkcfg(1, VT[v].sz, 0, 1));
      set_desc(32'h140, 0, {20'd0, VT[v].dp}, {24'd0, VT[v].n}, mkcfg(1, VT[v].sz, 1, 1));
      stall = VT[v].st;
      i0 = ndirq; d0 = nsirq;
      kick(32'h100, 32'h140);
      wait_irq(i0 + 1, "R6 irq");
      check_copy("R4 copy", VT[v].so, VT[v].dp, VT[v].n << VT[v].sz);
      chk(mem[32'h110 >> 2] == 32'h1 && mem[32'h150 >> 2] == 32'h1, "R2 status",
          mem[32'h150 >> 2], 32'h1);
      chk(ndirq == i0 + 1 && nsirq == d0, "R6 irq count", ndirq - i0, 1);
    end
    stall = 0;

    // R3 full stall, R1 busy start
    clear_dst();
    set_desc(32'h180, 0, 32'h400, 4, mkcfg(1, 2, 0, 1));
    set_desc(32'h100, 0, 32'h400, 40, mkcfg(1, 2, 0, 1));
    set_desc(32'h140, 0, 32'h800, 40, mkcfg(1, 2, 1, 1));
    d0 = nsread; d1 = ndwrite; i0 = ndirq; d2 = nalt;
    kick(32'h100, 32'h140);
    while (nsread == d0) @(negedge clk);
    d_hold = 1'b1;
    src_head = 32'h180; src_start = 1'b1;
    @(negedge clk);
    src_start = 1'b0;
    repeat (150) @(negedge clk);
    chk((nsread - d0) - (ndwrite - d1) == 16, "R3 full", (nsread - d0) - (ndwrite - d1), 16);
    chk(nalt == d2, "R1 busy start", nalt - d2, 0);
    s_hold = 1'b1; d_hold = 1'b0;
    repeat (150) @(negedge clk);
    chk(nsread - d0 == ndwrite - d1, "R3 empty", ndwrite - d1, nsread - d0);
    s_hold = 1'b0;
    wait_irq(i0 + 1, "R3 finish");
    check_copy("R3 copy", 32'h400, 32'h800, 160);

    // R5 count mismatch
    clear_dst();
    set_desc(32'h100, 0, 32'h400, 8, mkcfg(1, 2, 1, 1));
    set_desc(32'h140, 0, 32'h800, 9, mkcfg(1, 2, 1, 1));
    d1 = ndwrite; i0 = ndirq; d0 = nsirq;
    kick(32'h100, 32'h140);
    repeat (200) @(negedge clk);
    chk(pair_err, "R5 count flag", pair_err, 1);
    chk(mem[32'h110 >> 2] == 32'h2 && mem[32'h150 >> 2] == 32'h2, "R5 status",
        mem[32'h110 >> 2], 32'h2);
    chk(ndwrite == d1 && getb(32'h800) == 8'h00, "R5 no data", ndwrite - d1, 0);
    chk(ndirq == i0 && nsirq == d0, "R6 no irq on error", ndirq - i0, 0);

    // R5 size mismatch
    set_desc(32'h100, 0, 32'h400, 8, mkcfg(1, 0, 0, 1));
    set_desc(32'h140, 0, 32'h800, 8, mkcfg(1, 1, 0, 1));
    kick(32'h100, 32'h140);
    repeat (200) @(negedge clk);
    chk(pair_err && mem[32'h150 >> 2] == 32'h2, "R5 size", mem[32'h150 >> 2], 32'h2);

    // R10 zero count, src interrupt enabled
    set_desc(32'h100, 0, 32'h400, 0, mkcfg(1, 2, 1, 1));
    set_desc(32'h140, 0, 32'h800, 0, mkcfg(1, 2, 1, 1));
    d1 = ndwrite; i0 = ndirq; d0 = nsirq;
    kick(32'h100, 32'h140);
    wait_irq(i0 + 1, "R10 irq");
    chk(mem[32'h110 >> 2] == 32'h1 && mem[32'h150 >> 2] == 32'h1 && ndwrite == d1,
        "R10 zero count", ndwrite - d1, 0);
    chk(nsirq == d0 + 1, "R6 src irq", nsirq - d0, 1);
    chk(!pair_err, "R5 cleared", pair_err, 0);

    // R9 both disabled
    set_desc(32'h100, 0, 32'h400, 6, mkcfg(0, 2, 1, 1));
    set_desc(32'h140, 0, 32'h800, 6, mkcfg(0, 2, 1, 1));
    d1 = ndwrite; i0 = ndirq;
    kick(32'h100, 32'h140);
    repeat (100) @(negedge clk);
    chk(mem[32'h110 >> 2] == 32'hDEAD && mem[32'h150 >> 2] == 32'hDEAD, "R9 no status",
        mem[32'h150 >> 2], 32'hDEAD);
    chk(ndwrite == d1 && ndirq == i0 && !pair_err, "R9 no data", ndwrite - d1, 0);

    // R7 chain of two pairs
    clear_dst();
    set_desc(32'h100, 32'h1A0, 32'h400, 10, mkcfg(1, 2, 0, 0));
    set_desc(32'h140, 32'h1C0, 32'h800, 10, mkcfg(1, 2, 1, 0));
    set_desc(32'h1A0, 0, 32'h500, 12, mkcfg(1, 1, 0, 1));
    set_desc(32'h1C0, 32'h140, 32'h880, 12, mkcfg(1, 1, 1, 1));
    i0 = ndirq;
    stall = 1'b1;
    kick(32'h100, 32'h140);
    wait_irq(i0 + 2, "R7 two irqs");
    stall = 1'b0;
    check_copy("R7 first", 32'h400, 32'h800, 40);
    check_copy("R7 second", 32'h500, 32'h880, 24);
    chk(mem[32'h1B0 >> 2] == 32'h1 && mem[32'h1D0 >> 2] == 32'h1, "R7 status",
        mem[32'h1D0 >> 2], 32'h1);
    d3 = nreq;
    repeat (50) @(negedge clk);
    chk(nreq == d3 && ndirq == i0 + 2, "R7 last stops", nreq - d3, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule